// File: doc/BRIEF.md
# Inter-Processor Message FIFO Mailbox

This block carries 32-bit messages in one direction between two processors. The sending side owns a small register window. Through it the sender pushes messages, reads status and programs control. The receiving side sees the same window from its own bus port. Through that port it pops or peeks at messages and reads the shared status. A bidirectional link is built from two instances.

Messages sit in a circular buffer of sixteen entries, of which fifteen are usable. The sender can set a lock flag. While it is set, further pushes are refused, and the receiver sees the flag in status until the sender clears it again. A flush bit empties the buffer at once. A programmable watermark drives an almost-full flag. Two interrupt lines are provided. Message-ready goes to the receiver and space-available goes to the sender, and each one is cleared by writing a one to its control bit.

Both bus ports are simple single-cycle register ports. Read data is combinational and valid in the cycle of the request. Pops, pushes and control writes take effect at the next clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the buffer is empty, both pointers are 0, the lock is clear, the watermark is 15 and both interrupts are low; status reads 0x0000_0008 and control reads 0x00F0_0000.
- R2: A sender write to offset 0x00 stores the word at the write pointer. A receiver read of offset 0x04 returns the oldest word and removes it, so words leave in arrival order. A receiver read of offset 0x10 returns the oldest word without removing it.
- R3: With 15 words held, status bit 2 (full) is 1, and a write to 0x00 changes neither the contents, the pointers nor the count.
- R4: A receiver read of 0x04 while empty returns 0 and changes neither pointers nor count.
- R5: Status (offset 0x08, readable from both ports) packs bit 0 locked, bit 1 almost full, bit 2 full, bit 3 empty, bits 8:4 count, bits 19:16 write pointer and bits 23:20 read pointer. All other bits read 0.
- R6: Control bit 17 (lock) is read/write from the sender. Status bit 0 follows it, and sender writes to 0x00 are ignored while it is 1.
- R7: Control bits 23:20 hold the watermark (read/write, reset 15). A write of 0 to this field leaves the old value. Status bit 1 is 1 whenever count is greater than or equal to the watermark.
- R8: A sender write with control bit 16 set empties the buffer and returns both pointers to 0. It takes priority over a receiver pop in the same cycle, and the bit always reads back 0.
- R9: The message-ready interrupt rises on every accepted push. It falls when either port writes control with bit 0 set, and a push in the same cycle as a clear leaves it high.
- R10: The space-available interrupt rises when a pop without a concurrent push takes the count from the watermark to one below it. It falls when the sender writes control with bit 1 set.
- R11: A push and a pop in the same cycle leave the count unchanged, advance both pointers by one and hand the oldest word to the reader.
- R12: Both pointers wrap from 15 to 0, so traffic continues correctly past the end of the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_en | input | 1 | Sender port access strobe |
| s_we | input | 1 | Sender port write (1) or read (0) |
| s_addr | input | ADDR_W | Sender port byte offset |
| s_wdata | input | DW | Sender port write data |
| s_rdata | output | DW | Sender port read data (combinational) |
| r_en | input | 1 | Receiver port access strobe |
| r_we | input | 1 | Receiver port write (1) or read (0) |
| r_addr | input | ADDR_W | Receiver port byte offset |
| r_wdata | input | DW | Receiver port write data (only bit 0 used, at 0x0C) |
| r_rdata | output | DW | Receiver port read data (combinational) |
| irq_msg_ready | output | 1 | Message-ready interrupt to the receiver |
| irq_space_avail | output | 1 | Space-available interrupt to the sender |

## Verification
Two actions can land on the same clock edge because the two ports are independent. The first is a sender push against a receiver pop. The second is a sender flush against a receiver pop. The bench drives both ports in one cycle for each pairing. For push against pop it judges that the count holds, both pointer fields in status advance and the reader gets the old head. For flush against pop it judges that status shows an empty buffer with both pointers at zero and that the next pop returns 0. A further same-cycle case, a push against a message-ready clear, checks that the interrupt stays high.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

   // register offsets inside the window (software decodes these)
   localparam logic [7:0] OFS_PUSH = 8'h00;
   localparam logic [7:0] OFS_POP  = 8'h04;
   localparam logic [7:0] OFS_STAT = 8'h08;
   localparam logic [7:0] OFS_CTRL = 8'h0C;
   localparam logic [7:0] OFS_PEEK = 8'h10;

   // control field positions
   localparam int unsigned CT_CLR_RDY = 0;
   localparam int unsigned CT_CLR_SPC = 1;
   localparam int unsigned CT_FLUSH   = 16;
   localparam int unsigned CT_LOCK    = 17;
   localparam int unsigned CT_WM_LO   = 20;
   localparam int unsigned WM_W       = 4;

   typedef struct packed {
      logic [3:0] rd_ptr;
      logic [3:0] wr_ptr;
      logic [6:0] rsv;
      logic [4:0] count;
      logic       empty;
      logic       full;
      logic       afull;
      logic       locked;
   } mbox_status_t;

   function automatic logic [31:0] pack_status(input logic locked, input logic afull,
                                               input logic full, input logic empty,
                                               input logic [4:0] cnt, input logic [3:0] wp,
                                               input logic [3:0] rp);
      mbox_status_t s;
      s.rd_ptr = rp;
      s.wr_ptr = wp;
      s.rsv    = '0;
      s.count  = cnt;
      s.empty  = empty;
      s.full   = full;
      s.afull  = afull;
      s.locked = locked;
      return {8'h00, s};
   endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic          flush,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] head,
   output logic [PW-1:0] wr_ptr,
   output logic [PW-1:0] rd_ptr,
   output logic [CW-1:0] count
);

   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      end else if (push && !flush) begin
         mem_q[wr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + PW'(1);
         if (pop)  rd_q <= rd_q + PW'(1);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: ;
         endcase
      end
   end

   assign head   = mem_q[rd_q];
   assign wr_ptr = wr_q;
   assign rd_ptr = rd_q;
   assign count  = cnt_q;

   // R3: never more than DEPTH-1 words held
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH - 1));

   // R4: the caller never pops an empty ring
   p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0);

   // R8: flush leaves an empty ring with pointers at zero
   p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0 && wr_q == '0 && rd_q == '0));

   // R11: simultaneous push and pop keep the count and move both pointers
   p_pushpop_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !flush) |=> ($stable(cnt_q) && rd_q == $past(rd_q) + PW'(1)
                                    && wr_q == $past(wr_q) + PW'(1)));

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
   parameter int unsigned DW     = 32,
   parameter int unsigned CW     = 5,
   parameter int unsigned WM_RST = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [DW-1:0] cfg_wdata,
   input  logic          peer_clr_rdy,
   input  logic          push_done,
   input  logic          pop_done,
   input  logic [CW-1:0] count,
   output logic          locked,
   output logic [3:0]    wmark,
   output logic          irq_rdy,
   output logic          irq_spc
);
   import ipc_mbox_pkg::*;

   logic       lock_q, rdy_q, spc_q;
   logic [3:0] wm_q;
   logic [3:0] wm_in;
   logic       clr_rdy, clr_spc, spc_set;
   logic       unused_bits;

   assign wm_in   = cfg_wdata[CT_WM_LO +: WM_W];
   assign clr_rdy = (cfg_wr && cfg_wdata[CT_CLR_RDY]) || peer_clr_rdy;
   assign clr_spc = cfg_wr && cfg_wdata[CT_CLR_SPC];
   assign spc_set = pop_done && !push_done && (5'(count) == {1'b0, wm_q});
   assign unused_bits = ^cfg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         wm_q   <= 4'(WM_RST);
      end else if (cfg_wr) begin
         lock_q <= cfg_wdata[CT_LOCK];
         if (wm_in != '0) wm_q <= wm_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_q <= 1'b0;
         spc_q <= 1'b0;
      end else begin
         if (push_done)    rdy_q <= 1'b1;
         else if (clr_rdy) rdy_q <= 1'b0;
         if (spc_set)      spc_q <= 1'b1;
         else if (clr_spc) spc_q <= 1'b0;
      end
   end

   assign locked  = lock_q;
   assign wmark   = wm_q;
   assign irq_rdy = rdy_q;
   assign irq_spc = spc_q;

   // R7: watermark never holds the illegal value 0
   p_wm_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wm_q != '0);

   // R9: an accepted push always leaves message-ready high
   p_rdy_on_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push_done |=> rdy_q);

   // R10: space-available only rises after a pop
   p_spc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spc_q) |-> $past(pop_done));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int unsigned DW     = 32,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned WM_RST = DEPTH - 1,
   localparam int unsigned PW    = $clog2(DEPTH),
   localparam int unsigned CW    = PW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_en,
   input  logic              s_we,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DW-1:0]     s_wdata,
   output logic [DW-1:0]     s_rdata,
   input  logic              r_en,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DW-1:0]     r_wdata,
   output logic [DW-1:0]     r_rdata,
   output logic              irq_msg_ready,
   output logic              irq_space_avail
);
   import ipc_mbox_pkg::*;

   generate
      if (DEPTH < 2 || DEPTH > 16 || (DEPTH & (DEPTH - 1)) != 0)
         begin : g_bad_depth $error("DEPTH must be a power of two from 2 to 16"); end
      if (DW < 24)
         begin : g_bad_dw $error("DW must hold the 24-bit status word"); end
      if (ADDR_W < 5)
         begin : g_bad_aw $error("ADDR_W must reach offset 0x10"); end
      if (WM_RST < 1 || WM_RST > 15)
         begin : g_bad_wm $error("WM_RST must lie in 1..15"); end
   endgenerate

   logic          s_push_req, s_cfg_wr, r_pop_req, r_clr;
   logic          flush, push_ok, pop_ok;
   logic          locked, full, empty, afull;
   logic [3:0]    wmark;
   logic [DW-1:0] head, head_vis;
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic [DW-1:0] stat_word, ctrl_word;
   logic          unused_r;

   assign s_push_req = s_en &&  s_we && s_addr == ADDR_W'(OFS_PUSH);
   assign s_cfg_wr   = s_en &&  s_we && s_addr == ADDR_W'(OFS_CTRL);
   assign r_pop_req  = r_en && !r_we && r_addr == ADDR_W'(OFS_POP);
   assign r_clr      = r_en &&  r_we && r_addr == ADDR_W'(OFS_CTRL) && r_wdata[CT_CLR_RDY];
   assign unused_r   = ^r_wdata;

   assign flush   = s_cfg_wr && s_wdata[CT_FLUSH];
   assign full    = count == CW'(DEPTH - 1);
   assign empty   = count == '0;
   assign afull   = 5'(count) >= {1'b0, wmark};
   assign push_ok = s_push_req && !full && !locked && !flush;
   assign pop_ok  = r_pop_req && !empty && !flush;

   mbox_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push_ok),
      .pop    (pop_ok),
      .flush  (flush),
      .wdata  (s_wdata),
      .head   (head),
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .count  (count)
   );

   mbox_ctrl #(.DW(DW), .CW(CW), .WM_RST(WM_RST)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_wr       (s_cfg_wr),
      .cfg_wdata    (s_wdata),
      .peer_clr_rdy (r_clr),
      .push_done    (push_ok),
      .pop_done     (pop_ok),
      .count        (count),
      .locked       (locked),
      .wmark        (wmark),
      .irq_rdy      (irq_msg_ready),
      .irq_spc      (irq_space_avail)
   );

   assign stat_word = DW'(pack_status(locked, afull, full, empty, 5'(count),
                                      4'(wr_ptr), 4'(rd_ptr)));

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CT_LOCK] = locked;
      ctrl_word[CT_WM_LO +: WM_W] = wmark;
   end

   assign head_vis = empty ? '0 : head;

   always_comb begin
      s_rdata = '0;
      if (s_en && !s_we) begin
         if (s_addr == ADDR_W'(OFS_STAT))      s_rdata = stat_word;
         else if (s_addr == ADDR_W'(OFS_CTRL)) s_rdata = ctrl_word;
      end
   end

   always_comb begin
      r_rdata = '0;
      if (r_en && !r_we) begin
         if (r_addr == ADDR_W'(OFS_POP) || r_addr == ADDR_W'(OFS_PEEK)) r_rdata = head_vis;
         else if (r_addr == ADDR_W'(OFS_STAT))                           r_rdata = stat_word;
         else if (r_addr == ADDR_W'(OFS_CTRL))                           r_rdata = ctrl_word;
      end
   end

   // R3: a push into a full buffer without a pop leaves the count alone
   p_full_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && s_push_req && !r_pop_req) |=> count == $past(count));

   // R4: popping an empty buffer returns zero
   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (r_pop_req && empty) |-> r_rdata == '0);

   // R6: while locked the count can never grow
   p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && s_push_req) |=> count <= $past(count));

   // R5: empty and full flags are never both set
   p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat_word[3] && stat_word[2]));

endmodule

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_en = 0, s_we = 0, r_en = 0, r_we = 0;
   logic [4:0]  s_addr = '0, r_addr = '0;
   logic [31:0] s_wdata = '0, r_wdata = '0;
   logic [31:0] s_rdata, r_rdata;
   logic        irq_msg_ready, irq_space_avail;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ipc_mailbox uut (
      .clk(clk), .rst_n(rst_n),
      .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
      .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
      .irq_msg_ready(irq_msg_ready), .irq_space_avail(irq_space_avail)
   );

   function automatic logic [31:0] st(input logic lk, input logic af, input logic fu,
                                      input logic em, input int cnt, input int wp, input int rp);
      return {8'h00, 4'(rp), 4'(wp), 7'h00, 5'(cnt), em, fu, af, lk};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic s_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      s_en = 1; s_we = 1; s_addr = a; s_wdata = d;
      @(negedge clk);
      s_en = 0; s_we = 0;
   endtask

   task automatic s_rd(input logic [4:0] a, output logic [31:0] q);
      @(negedge clk);
      s_en = 1; s_we = 0; s_addr = a;
      #1 q = s_rdata;
      @(negedge clk);
      s_en = 0;
   endtask

   task automatic r_wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      r_en = 1; r_we = 1; r_addr = a; r_wdata = d;
      @(negedge clk);
      r_en = 0; r_we = 0;
   endtask

   task automatic r_rd(input logic [4:0] a, output logic [31:0] q);
      @(negedge clk);
      r_en = 1; r_we = 0; r_addr = a;
      #1 q = r_rdata;
      @(negedge clk);
      r_en = 0;
   endtask

   task automatic status_is(input string tag, input logic [31:0] exp);
      logic [31:0] q;
      s_rd(5'h08, q);
      chk(tag, q, exp);
   endtask

   task automatic t_reset();
      logic [31:0] q;
      status_is("R1 reset status", 32'h0000_0008);
      s_rd(5'h0C, q); chk("R1 reset control", q, 32'h00F0_0000);
      chk("R1 reset irq_msg_ready", {31'b0, irq_msg_ready}, 0);
      chk("R1 reset irq_space_avail", {31'b0, irq_space_avail}, 0);
      r_rd(5'h04, q); chk("R4 pop empty returns 0", q, 0);
      status_is("R4 pop empty no change", 32'h0000_0008);
   endtask

   task automatic t_basic();
      logic [31:0] q;
      s_wr(5'h00, 32'hA1); s_wr(5'h00, 32'hB2); s_wr(5'h00, 32'hC3);
      chk("R9 msg ready after push", {31'b0, irq_msg_ready}, 1);
      status_is("R5 status three held", st(0,0,0,0,3,3,0));
      r_rd(5'h10, q); chk("R2 peek head", q, 32'hA1);
      r_rd(5'h08, q); chk("R2 peek keeps count (rx view)", q, st(0,0,0,0,3,3,0));
      r_rd(5'h04, q); chk("R2 pop first", q, 32'hA1);
      r_rd(5'h04, q); chk("R2 pop second", q, 32'hB2);
      r_rd(5'h04, q); chk("R2 pop third", q, 32'hC3);
      status_is("R5 status drained", st(0,0,0,1,0,3,3));
      r_rd(5'h04, q); chk("R4 pop empty again", q, 0);
      r_wr(5'h0C, 32'h1);
      chk("R9 receiver clears msg ready", {31'b0, irq_msg_ready}, 0);
      chk("R10 no space irq below mark", {31'b0, irq_space_avail}, 0);
   endtask

   task automatic t_flush();
      logic [31:0] q;
      s_wr(5'h00, 32'h11); s_wr(5'h00, 32'h22);
      s_wr(5'h0C, 32'h00F1_0000);
      status_is("R8 flush empties", 32'h0000_0008);
      s_rd(5'h0C, q); chk("R8 flush reads back 0", q, 32'h00F0_0000);
   endtask

   task automatic t_full();
      logic [31:0] q;
      for (int i = 0; i < 15; i++) s_wr(5'h00, 32'h100 + i);
      status_is("R3 full after 15", st(0,1,1,0,15,15,0));
      s_wr(5'h00, 32'h1FF);
      status_is("R3 push while full ignored", st(0,1,1,0,15,15,0));
      r_rd(5'h04, q); chk("R3 first out after full", q, 32'h100);
      chk("R10 space irq on 15 to 14", {31'b0, irq_space_avail}, 1);
      s_wr(5'h0C, 32'h00F0_0002);
      chk("R10 sender clears space irq", {31'b0, irq_space_avail}, 0);
      for (int i = 1; i < 15; i++) begin
         r_rd(5'h04, q); chk("R2 order after full", q, 32'h100 + i);
      end
      status_is("R3 dropped word absent", st(0,0,0,1,0,15,15));
   endtask

   task automatic t_wrap();
      logic [31:0] q;
      s_wr(5'h00, 32'hD0); s_wr(5'h00, 32'hD1);
      status_is("R12 write pointer wraps", st(0,0,0,0,2,1,15));
      r_rd(5'h04, q); chk("R12 pop at entry 15", q, 32'hD0);
      r_rd(5'h04, q); chk("R12 pop at entry 0", q, 32'hD1);
      status_is("R12 read pointer wraps", st(0,0,0,1,0,1,1));
   endtask

   task automatic t_lock();
      logic [31:0] q;
      s_wr(5'h0C, 32'h00F2_0000);
      status_is("R6 lock shows in status", st(1,0,0,1,0,1,1));
      s_rd(5'h0C, q); chk("R6 lock reads back", q, 32'h00F2_0000);
      s_wr(5'h00, 32'hEE);
      status_is("R6 push while locked ignored", st(1,0,0,1,0,1,1));
      r_rd(5'h04, q); chk("R6 nothing to pop while locked", q, 0);
      s_wr(5'h0C, 32'h00F0_0000);
      status_is("R6 unlock clears flag", st(0,0,0,1,0,1,1));
      s_wr(5'h00, 32'hEF);
      r_rd(5'h04, q); chk("R6 push after unlock", q, 32'hEF);
   endtask

   task automatic t_wmark();
      logic [31:0] q;
      s_wr(5'h0C, 32'h0030_0000);
      s_rd(5'h0C, q); chk("R7 watermark reads back", q, 32'h0030_0000);
      s_wr(5'h00, 32'h1); s_wr(5'h00, 32'h2);
      status_is("R7 below mark", st(0,0,0,0,2,4,2));
      s_wr(5'h00, 32'h3);
      status_is("R7 at mark almost full", st(0,1,0,0,3,5,2));
      s_wr(5'h0C, 32'h0000_0000);
      s_rd(5'h0C, q); chk("R7 zero mark ignored", q, 32'h0030_0000);
      r_rd(5'h04, q); chk("R7 pop value", q, 32'h1);
      chk("R10 space irq on 3 to 2", {31'b0, irq_space_avail}, 1);
      s_wr(5'h0C, 32'h0030_0002);
      chk("R10 cleared again", {31'b0, irq_space_avail}, 0);
   endtask

   task automatic t_pushpop();
      logic [31:0] q;
      @(negedge clk);
      s_en = 1; s_we = 1; s_addr = 5'h00; s_wdata = 32'h55;
      r_en = 1; r_we = 0; r_addr = 5'h04;
      #1 q = r_rdata;
      @(negedge clk);
      s_en = 0; s_we = 0; r_en = 0;
      chk("R11 concurrent pop data", q, 32'h2);
      status_is("R11 count held pointers moved", st(0,0,0,0,2,6,4));
      chk("R11 no space irq on held count", {31'b0, irq_space_avail}, 0);
      r_wr(5'h0C, 32'h1);
      chk("R9 cleared before race", {31'b0, irq_msg_ready}, 0);
      @(negedge clk);
      s_en = 1; s_we = 1; s_addr = 5'h00; s_wdata = 32'h66;
      r_en = 1; r_we = 1; r_addr = 5'h0C; r_wdata = 32'h1;
      @(negedge clk);
      s_en = 0; s_we = 0; r_en = 0; r_we = 0;
      chk("R9 push beats clear", {31'b0, irq_msg_ready}, 1);
      status_is("R11 push landed", st(0,1,0,0,3,7,4));
   endtask

   task automatic t_flush_race();
      logic [31:0] q;
      @(negedge clk);
      s_en = 1; s_we = 1; s_addr = 5'h0C; s_wdata = 32'h0031_0000;
      r_en = 1; r_we = 0; r_addr = 5'h04;
      @(negedge clk);
      s_en = 0; s_we = 0; r_en = 0;
      status_is("R8 flush wins over pop", 32'h0000_0008);
      r_rd(5'h04, q); chk("R8 nothing left after flush", q, 0);
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_flush();
      t_full();
      t_wrap();
      t_lock();
      t_wmark();
      t_pushpop();
      t_flush_race();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule